// File: doc/BRIEF.md
# DPCM Sample Fetch Controller

This block feeds a delta-modulation sample player. It fetches the bytes of a sample, one byte at a time, from a 16-bit address space. Software programs four write-only registers: control (interrupt enable, loop enable, rate index), a direct output level, the sample start address and the sample length. Start address and length are each packed into one byte. The controller keeps a current read pointer and a count of the bytes still to fetch. It asks memory for the next byte whenever its one-byte sample buffer is empty and bytes remain.

Memory is reached through a request/acknowledge port. `fetch_req` rises with `fetch_addr`, and both stay steady until `fetch_ack` returns with `fetch_data` in the same cycle. The fetched byte is handed to the playback unit over a valid/ready stream. Back-pressure rule: while `smp_valid` is high and `smp_ready` is low, `smp_data` stays fixed and no new fetch is requested, because the buffer is full. The byte leaves the buffer on the cycle where both are high.

Playback is started and stopped with an enable strobe. Both directions act after a short delay whose length depends on the parity of a free-running cycle bit. When a non-looping sample ends, a sticky interrupt can be raised.

Top module: `dpcm_fetch_ctrl`

## Requirements
- R1: A write with `wr_sel`=0 sets interrupt enable from bit 7, loop enable from bit 6 and `rate_sel` from bits 3:0. A write with `wr_sel`=1 sets `direct_level` from bits 6:0. All of these are visible on the cycle after the write.
- R2: A write with `wr_sel`=2 and value v sets the start address to 0xC000 | (v << 6). A write with `wr_sel`=3 sets the length to (v << 4) | 1 bytes.
- R3: `fetch_req` is high exactly when the buffer is empty, the remaining count is non-zero and no start delay is pending. Without `fetch_ack`, the request and `fetch_addr` hold steady.
- R4: An accepted acknowledge stores `fetch_data` and decrements the remaining count. It also advances the current address by one, where 0xFFFF is followed by 0x8000.
- R5: The buffered byte is offered on `smp_valid`/`smp_data`. It stays there unchanged until `smp_ready` is high.
- R6: When the last byte of a sample is accepted with loop disabled and interrupt enable set, `irq` goes high and stays high.
- R7: With loop enabled, accepting the last byte reloads the start address and length, and `irq` is not raised.
- R8: `irq` is cleared by `irq_clr` or by a control write with bit 7 clear. A clear wins over a set in the same cycle.
- R9: An enable strobe (`en_wr` with `en_val`=1) while the remaining count is zero reloads the start address and length. The first request then appears 2 cycles later if the parity bit was 0 and 3 if it was 1. The parity bit is 0 in the first cycle after any reset and toggles every cycle. An enable strobe while bytes remain has no effect.
- R10: A disable strobe (`en_wr` with `en_val`=0) clears the remaining count after the same 2/3-cycle parity delay. An acknowledge in the expiry cycle is discarded, and later acknowledges are ignored.
- R11: `active` is high exactly when the remaining count is non-zero.
- R12: Power-on reset sets start address 0xC000 and length 1, and clears everything else. `soft_rst` clears all state except the start address and length registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 level, 2 address, 3 length |
| wr_data | input | 8 | Register write value |
| en_wr | input | 1 | Enable/disable strobe |
| en_val | input | 1 | 1 = enable, 0 = disable |
| irq_clr | input | 1 | Interrupt clear strobe |
| fetch_req | output | 1 | Byte fetch request |
| fetch_addr | output | 16 | Byte fetch address |
| fetch_ack | input | 1 | Fetch acknowledge, data valid |
| fetch_data | input | 8 | Fetched byte |
| smp_valid | output | 1 | Sample byte available |
| smp_ready | input | 1 | Playback unit takes the byte |
| smp_data | output | 8 | Sample byte |
| rate_sel | output | 4 | Rate table index for the playback unit |
| direct_level | output | 7 | Directly written output level |
| irq | output | 1 | Sticky end-of-sample interrupt |
| active | output | 1 | Bytes remain to fetch |

## Verification
The hardest case to reach is a disable whose delay window overlaps a pending request. The acknowledge must either fall inside the window, where the byte is still taken, or on the expiry cycle, where it is discarded. To get there, the bench holds acknowledges off so that a request waits, picks the parity bit before each strobe so that both delay lengths are used, and forces a constant acknowledge after the stop. The address wrap is reached by a 65-byte sample placed at 0xFFC0. A one-byte looping sample keeps the reload path running under an alternating ready pattern.

// File: rtl/dpcm_fetch_pkg.sv
package dpcm_fetch_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LEN_W  = DATA_W + 4;
  localparam int unsigned RATE_W = 4;
  localparam int unsigned LVL_W  = DATA_W - 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [LEN_W-1:0]  len_t;

  localparam addr_t START_BASE = addr_t'(16'hC000);
  localparam addr_t WRAP_TO    = addr_t'(16'h8000);
  localparam addr_t ADDR_TOP   = addr_t'(16'hFFFF);

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_LEVEL = 2'd1,
    SEL_ADDR  = 2'd2,
    SEL_LEN   = 2'd3
  } reg_sel_e;

  function automatic addr_t start_of(input logic [DATA_W-1:0] v);
    return START_BASE | {2'b00, v, 6'b000000};
  endfunction

  function automatic len_t len_of(input logic [DATA_W-1:0] v);
    return {v, 4'b0001};
  endfunction

  function automatic addr_t step_addr(input addr_t a);
    return (a == ADDR_TOP) ? WRAP_TO : a + addr_t'(1);
  endfunction
endpackage

// File: rtl/dpcm_cfg_regs.sv
module dpcm_cfg_regs
  import dpcm_fetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq_en,
  output logic              loop_en,
  output logic [RATE_W-1:0] rate,
  output logic [LVL_W-1:0]  level,
  output addr_t             start_addr,
  output len_t              start_len
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en     <= 1'b0;
      loop_en    <= 1'b0;
      rate       <= '0;
      level      <= '0;
      start_addr <= START_BASE;
      start_len  <= len_t'(1);
    end else if (soft_rst) begin
      irq_en  <= 1'b0;
      loop_en <= 1'b0;
      rate    <= '0;
      level   <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_CTRL: begin
          irq_en  <= wr_data[7];
          loop_en <= wr_data[6];
          rate    <= wr_data[RATE_W-1:0];
        end
        SEL_LEVEL: level      <= wr_data[LVL_W-1:0];
        SEL_ADDR:  start_addr <= start_of(wr_data);
        SEL_LEN:   start_len  <= len_of(wr_data);
        default: ;
      endcase
    end
  end

  // R2: the length register always encodes an odd byte count
  assert_len_odd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && reg_sel_e'(wr_sel) == SEL_LEN && !soft_rst |=> start_len[0]);
endmodule

// File: rtl/dpcm_ptr_unit.sv
module dpcm_ptr_unit
  import dpcm_fetch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_rst,
  input  logic  load,
  input  logic  take,
  input  logic  kill,
  input  logic  loop_en,
  input  addr_t start_addr,
  input  len_t  start_len,
  output addr_t cur_addr,
  output len_t  remain,
  output logic  last
);
  localparam len_t LEN_MAX = {{DATA_W{1'b1}}, 4'b0001};

  assign last = (remain == len_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (soft_rst) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (kill) begin
      remain <= '0;
    end else if (take) begin
      if (last && loop_en) begin
        cur_addr <= start_addr;
        remain   <= start_len;
      end else begin
        cur_addr <= step_addr(cur_addr);
        remain   <= remain - len_t'(1);
      end
    end else if (load) begin
      cur_addr <= start_addr;
      remain   <= start_len;
    end
  end

  // R4: after any accepted byte the pointer lies in the upper half of memory
  assert_addr_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take && !kill && !soft_rst |=> cur_addr[ADDR_W-1]);
  // R2: count never exceeds the largest encodable length
  assert_remain_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= LEN_MAX);
endmodule

// File: rtl/dpcm_en_timer.sv
module dpcm_en_timer #(
  parameter int unsigned DLY_EVEN = 2,
  parameter int unsigned DLY_ODD  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic en_wr,
  input  logic en_val,
  input  logic idle,
  output logic load,
  output logic start_hold,
  output logic kill
);
  localparam int unsigned CW = $clog2(DLY_ODD + 1);
  localparam logic [CW-1:0] D_EVEN = CW'(DLY_EVEN);
  localparam logic [CW-1:0] D_ODD  = CW'(DLY_ODD);

  logic          parity;
  logic [CW-1:0] start_cnt, stop_cnt, dly;

  assign dly        = parity ? D_ODD : D_EVEN;
  assign kill       = (stop_cnt == CW'(1));
  assign load       = en_wr && en_val && idle && !kill;
  assign start_hold = (start_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parity    <= 1'b0;
      start_cnt <= '0;
      stop_cnt  <= '0;
    end else if (soft_rst) begin
      parity    <= 1'b0;
      start_cnt <= '0;
      stop_cnt  <= '0;
    end else begin
      parity <= !parity;
      if (load)                   start_cnt <= dly;
      else if (start_cnt != '0)   start_cnt <= start_cnt - CW'(1);
      if (en_wr && !en_val && stop_cnt == '0) stop_cnt <= dly;
      else if (stop_cnt != '0)                stop_cnt <= stop_cnt - CW'(1);
    end
  end

  // R10: the stop action fires for a single cycle per disable strobe
  assert_kill_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !kill);
endmodule

// File: rtl/dpcm_fetch_ctrl.sv
module dpcm_fetch_ctrl
  import dpcm_fetch_pkg::*;
#(
  parameter int unsigned DLY_EVEN = 2,
  parameter int unsigned DLY_ODD  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              en_wr,
  input  logic              en_val,
  input  logic              irq_clr,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ack,
  input  logic [DATA_W-1:0] fetch_data,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [DATA_W-1:0] smp_data,
  output logic [RATE_W-1:0] rate_sel,
  output logic [LVL_W-1:0]  direct_level,
  output logic              irq,
  output logic              active
);
  logic  irq_en, loop_en, load, start_hold, kill, last, take, buf_full, irq_off;
  addr_t start_addr, cur_addr;
  len_t  start_len, remain;
  logic [DATA_W-1:0] buf_q;

  dpcm_cfg_regs u_cfg (
    .clk, .rst_n, .soft_rst, .wr_en, .wr_sel, .wr_data,
    .irq_en, .loop_en, .rate(rate_sel), .level(direct_level),
    .start_addr, .start_len
  );

  dpcm_en_timer #(.DLY_EVEN(DLY_EVEN), .DLY_ODD(DLY_ODD)) u_tmr (
    .clk, .rst_n, .soft_rst, .en_wr, .en_val,
    .idle(remain == '0), .load, .start_hold, .kill
  );

  dpcm_ptr_unit u_ptr (
    .clk, .rst_n, .soft_rst, .load, .take, .kill, .loop_en,
    .start_addr, .start_len, .cur_addr, .remain, .last
  );

  assign active     = (remain != '0);
  assign fetch_req  = !buf_full && active && !start_hold;
  assign fetch_addr = cur_addr;
  assign take       = fetch_req && fetch_ack && !kill;
  assign smp_valid  = buf_full;
  assign smp_data   = buf_q;
  assign irq_off    = soft_rst || irq_clr ||
                      (wr_en && reg_sel_e'(wr_sel) == SEL_CTRL && !wr_data[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_q    <= '0;
    end else if (soft_rst) begin
      buf_full <= 1'b0;
    end else if (take) begin
      buf_full <= 1'b1;
      buf_q    <= fetch_data;
    end else if (buf_full && smp_ready) begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  irq <= 1'b0;
    else if (irq_off)                            irq <= 1'b0;
    else if (take && last && !loop_en && irq_en) irq <= 1'b1;
  end

  // R3: a waiting request keeps its address
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_ack && !kill && !soft_rst |=> fetch_req && $stable(fetch_addr));
  // R5: a stalled sample byte is held unchanged
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready && !soft_rst |=> smp_valid && $stable(smp_data));
  // R7: a looping end never raises the interrupt
  assert_loop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take && last && loop_en && !irq && !soft_rst |=> !irq);
  // R9: a restart never requests in the next cycle
  assert_start_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load && !soft_rst |=> !fetch_req);
  // R11: requests only while bytes remain
  assert_req_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> active && !smp_valid);
endmodule

// File: tb/dpcm_fetch_ctrl_test.sv
`timescale 1ns/1ps
module dpcm_fetch_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, soft_rst = 1'b0;
  logic wr_en = 1'b0, en_wr = 1'b0, en_val = 1'b0, irq_clr = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0, fetch_data = '0;
  logic fetch_ack = 1'b0, smp_ready = 1'b0;
  logic fetch_req, smp_valid, irq, active;
  logic [15:0] fetch_addr;
  logic [7:0] smp_data;
  logic [3:0] rate_sel;
  logic [6:0] direct_level;

  always #2 clk = ~clk;

  dpcm_fetch_ctrl uut (
    .clk, .rst_n, .soft_rst, .wr_en, .wr_sel, .wr_data, .en_wr, .en_val,
    .irq_clr, .fetch_req, .fetch_addr, .fetch_ack, .fetch_data, .smp_valid,
    .smp_ready, .smp_data, .rate_sel, .direct_level, .irq, .active
  );

  int checks = 0, fails = 0, takes = 0;
  int ack_mode = 0, rdy_mode = 1;
  bit tgl = 1'b0, done = 1'b0, saw_wrap = 1'b0;
  int last_take = 0;

  // reference model state
  int m_irq_en, m_loop, m_rate, m_level, m_saddr, m_slen;
  int m_cur, m_rem, m_full, m_buf, m_irq, m_scnt, m_pcnt, m_par;

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irq_en = 0; m_loop = 0; m_rate = 0; m_level = 0;
      m_saddr = 'hC000; m_slen = 1;
      m_cur = 0; m_rem = 0; m_full = 0; m_buf = 0; m_irq = 0;
      m_scnt = 0; m_pcnt = 0; m_par = 0;
    end else if (soft_rst) begin
      m_irq_en = 0; m_loop = 0; m_rate = 0; m_level = 0;
      m_cur = 0; m_rem = 0; m_full = 0; m_irq = 0;
      m_scnt = 0; m_pcnt = 0; m_par = 0;
    end else begin
      int kill_i, req_i, take_i, last_i, load_i, dly;
      kill_i = (m_pcnt == 1);
      req_i  = (m_full == 0 && m_rem != 0 && m_scnt == 0);
      take_i = req_i && fetch_ack && !kill_i;
      last_i = take_i && m_rem == 1;
      load_i = en_wr && en_val && m_rem == 0 && !kill_i;
      dly    = m_par ? 3 : 2;
      if (irq_clr || (wr_en && wr_sel == 0 && !wr_data[7])) m_irq = 0;
      else if (last_i && !m_loop && m_irq_en) m_irq = 1;
      if (take_i) begin m_full = 1; m_buf = fetch_data; end
      else if (m_full != 0 && smp_ready) m_full = 0;
      if (kill_i) m_rem = 0;
      else if (take_i) begin
        if (last_i && m_loop != 0) begin m_cur = m_saddr; m_rem = m_slen; end
        else begin m_cur = (m_cur == 'hFFFF) ? 'h8000 : m_cur + 1; m_rem--; end
      end else if (load_i) begin m_cur = m_saddr; m_rem = m_slen; end
      if (load_i) m_scnt = dly; else if (m_scnt > 0) m_scnt--;
      if (en_wr && !en_val && m_pcnt == 0) m_pcnt = dly; else if (m_pcnt > 0) m_pcnt--;
      if (wr_en) case (wr_sel)
        2'd0: begin m_irq_en = wr_data[7]; m_loop = wr_data[6]; m_rate = wr_data[3:0]; end
        2'd1: m_level = wr_data[6:0];
        2'd2: m_saddr = 'hC000 | (int'(wr_data) << 6);
        default: m_slen = (int'(wr_data) << 4) | 1;
      endcase
      m_par = m_par ^ 1;
    end
  end

  always @(posedge clk) begin
    if (rst_n && fetch_req && fetch_ack) begin
      takes++;
      if (fetch_addr == 16'h8000 && last_take == 'hFFFF) saw_wrap = 1'b1;
      last_take = int'(fetch_addr);
    end
  end

  // compare against the model every cycle, then drive memory and sink
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int mreq;
      mreq = (m_full == 0 && m_rem != 0 && m_scnt == 0);
      cmp("R3 fetch_req", int'(fetch_req), mreq);
      if (mreq != 0) cmp("R4 fetch_addr", int'(fetch_addr), m_cur);
      cmp("R5 smp_valid", int'(smp_valid), m_full);
      if (m_full != 0) cmp("R5 smp_data", int'(smp_data), m_buf);
      cmp("R1 rate_sel", int'(rate_sel), m_rate);
      cmp("R1 direct_level", int'(direct_level), m_level);
      cmp("R6 irq", int'(irq), m_irq);
      cmp("R11 active", int'(active), int'(m_rem != 0));
    end
    tgl = !tgl;
    fetch_data = fetch_addr[7:0] ^ fetch_addr[15:8] ^ 8'h3C;
    case (ack_mode)
      1: fetch_ack = fetch_req;
      2: fetch_ack = fetch_req && tgl;
      3: fetch_ack = 1'b1;
      default: fetch_ack = 1'b0;
    endcase
    smp_ready = (rdy_mode == 1) || (rdy_mode == 2 && tgl);
  end

  task automatic wr(input int sel, input int val);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic enable_at(input int p);
    int n;
    while (m_par != p) @(negedge clk);
    en_wr = 1'b1; en_val = 1'b1;
    @(negedge clk);
    en_wr = 1'b0;
    n = 1;
    while (!fetch_req && n < 12) begin @(negedge clk); n++; end
    cmp("R9 start delay", n, (p != 0 ? 3 : 2) + 1);
  endtask

  task automatic disable_at(input int p);
    int n;
    while (m_par != p) @(negedge clk);
    en_wr = 1'b1; en_val = 1'b0;
    @(negedge clk);
    en_wr = 1'b0;
    n = 1;
    while (active && n < 12) begin @(negedge clk); n++; end
    cmp("R10 stop delay", n, (p != 0 ? 3 : 2) + 1);
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (active && n < 3000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R12 reset active", int'(active), 0);
    cmp("R12 reset fetch_req", int'(fetch_req), 0);
    cmp("R12 reset irq", int'(irq), 0);

    // power-on defaults: 0xC000, one byte
    takes = 0;
    enable_at(0);
    cmp("R12 default address", int'(fetch_addr), 'hC000);
    ack_mode = 1;
    wait_idle();
    cmp("R12 default length", takes, 1);

    // R1/R2/R6: programmed 17-byte sample with interrupt
    wr(0, 'h85); wr(1, 'h55); wr(2, 'h01); wr(3, 'h01);
    cmp("R1 rate field", int'(rate_sel), 5);
    cmp("R1 level field", int'(direct_level), 'h55);
    takes = 0;
    enable_at(1);
    cmp("R2 start address", int'(fetch_addr), 'hC040);
    wait_idle();
    cmp("R2 length bytes", takes, 17);
    repeat (4) @(negedge clk);
    cmp("R6 irq sticky", int'(irq), 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    cmp("R8 irq_clr", int'(irq), 0);

    // R4: 65-byte sample crossing the top of memory
    wr(2, 'hFF); wr(3, 'h04);
    saw_wrap = 1'b0; takes = 0;
    enable_at(0);
    cmp("R2 top address", int'(fetch_addr), 'hFFC0);
    wait_idle();
    cmp("R4 wrap to 0x8000", int'(saw_wrap), 1);
    cmp("R4 byte count", takes, 65);
    @(negedge clk);
    cmp("R6 irq after wrap sample", int'(irq), 1);
    wr(0, 'h05);
    cmp("R8 ctrl write clears irq", int'(irq), 0);

    // R5/R9: back-pressure and enable while busy
    wr(2, 'h02); wr(3, 'h01);
    rdy_mode = 0; takes = 0;
    enable_at(1);
    repeat (4) @(negedge clk);
    cmp("R5 byte held", int'(smp_valid), 1);
    cmp("R5 no request while full", int'(fetch_req), 0);
    en_wr = 1'b1; en_val = 1'b1; @(negedge clk); en_wr = 1'b0;
    rdy_mode = 1;
    wait_idle();
    cmp("R9 busy enable ignored", takes, 17);

    // R7: one-byte looping sample, then disable
    wr(0, 'hC0); wr(3, 'h00);
    rdy_mode = 2;
    enable_at(0);
    repeat (40) @(negedge clk);
    cmp("R7 loop keeps active", int'(active), 1);
    cmp("R7 loop no irq", int'(irq), 0);
    disable_at(1);
    rdy_mode = 1;
    repeat (3) @(negedge clk);
    ack_mode = 3;
    repeat (4) @(negedge clk);
    cmp("R10 ack ignored after stop", int'(smp_valid), 0);
    cmp("R10 stays inactive", int'(active), 0);

    // R10: disable while a request waits for memory
    ack_mode = 0;
    wr(0, 'h00); wr(3, 'h01);
    enable_at(0);
    cmp("R3 request waits", int'(fetch_req), 1);
    disable_at(0);
    cmp("R10 request withdrawn", int'(fetch_req), 0);

    // R12: soft reset keeps start registers
    wr(2, 'h10); wr(1, 'h22); wr(0, 'h83);
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    cmp("R12 soft level", int'(direct_level), 0);
    cmp("R12 soft rate", int'(rate_sel), 0);
    cmp("R12 soft active", int'(active), 0);
    ack_mode = 1;
    enable_at(1);
    cmp("R12 address kept", int'(fetch_addr), 'hC400);
    wait_idle();
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule